// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash. It takes one request at a time: program a byte, erase a sector, erase a block, or erase the whole chip. For each request it issues the protected unlock write sequence on a simple synchronous port. The port has a one-cycle write strobe, a one-cycle read strobe, and a read-data-valid return. After the sequence, the block waits for the flash to finish and reports the outcome. It pulses `done` on completion. If the flash overruns its time budget, it sends one reset write and then pulses `error`.

Completion is detected in one of three ways, chosen per request:

- **Data-bit polling:** bit 7 of a status read is compared with the expected bit 7.
- **Toggle comparison:** bit 6 of each read is compared with bit 6 of the read before it.
- **Fixed wait:** a set cycle count is waited out with no reads.

A status read can look finished in the same instant that the flash actually finishes. To avoid a false result from such a read, a read that looks finished must be followed by two more reads that also look finished. Only then is `done` raised.

The controller is a single state machine with eight states:

| State | Transition out |
|---|---|
| ST_IDLE | To ST_UNLOCK when a request is accepted. |
| ST_UNLOCK | Issues one command write per cycle. To ST_RD_ISSUE after the last write, or to ST_FIX_WAIT in fixed-wait mode. |
| ST_RD_ISSUE | Issues a status read, then goes to ST_RD_WAIT. |
| ST_RD_WAIT | Waits for read data. Goes back to ST_RD_ISSUE, or to ST_DONE after three consecutive completion reads. |
| ST_FIX_WAIT | To ST_DONE when the wait count is reached. |
| ST_ABORT | Entered from ST_RD_ISSUE or ST_RD_WAIT when the timeout expires. Issues the reset write, then goes to ST_FAIL. |
| ST_DONE | To ST_IDLE. |
| ST_FAIL | To ST_IDLE. |

Top module: `flash_wr_seq`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1. `busy`, `done`, `error`, `fl_wr` and `fl_rd` are 0, and they stay 0 in every idle cycle.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle through the cycle that carries `done` or `error`, `busy` is 1 and `req_ready` is 0. While busy, `req_valid` is ignored. The cycle after `done` or `error` is idle.
- R3: A program request (`req_op`=0) issues four writes on consecutive cycles 1 to 4 after acceptance, in this order:
  1. AAh at 5555h
  2. 55h at 2AAAh
  3. A0h at 5555h
  4. the request data at the request address
- R4: An erase request issues six writes on consecutive cycles 1 to 6 after acceptance. The first five are AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. The sixth write depends on the erase type:
  - sector erase (`req_op`=1): 30h at the request address
  - block erase (`req_op`=2): 50h at the request address
  - chip erase (`req_op`=3): 10h at 5555h
- R5: In polling modes, every status read goes to the request address, and a read strobe is never raised together with a write strobe. In bit-7 mode (`req_mode`=0), a read counts as finished when its bit 7 equals bit 7 of the request data for a program, or equals 1 for any erase.
- R6: In toggle mode (`req_mode`=1), a read counts as finished when its bit 6 equals bit 6 of the previous status read of the same request. The first status read never counts as finished.
- R7: `done` is raised for one cycle, one cycle after the read data of the third finished read in an unbroken run. Any unfinished read restarts the run. With R status reads in total and N writes, `done` is in cycle N+2R+1 after acceptance.
- R8: In fixed-wait mode (`req_mode`=2 or 3), no status reads are issued. `done` is raised in cycle N+W+2 after acceptance. W is the wait parameter for the operation: `WAIT_PROG`, `WAIT_ERASE` (sector and block), or `WAIT_CHIP`.
- R9: In polling modes, the limit T is `TMO_PROG`, `TMO_ERASE` or `TMO_CHIP`, chosen by operation type. If completion has not been reached by cycle N+T+1 after acceptance:
  - cycle N+T+2 carries one write of F0h at 5555h;
  - cycle N+T+3 carries `error` for one cycle;
  - `done` is not raised.
- R10: The encodings are:
  - `req_op`: 0 program, 1 sector erase, 2 block erase, 3 chip erase.
  - `req_mode`: 0 bit-7 polling, 1 toggle, 2 and 3 fixed wait.

  Command addresses 5555h and 2AAAh are zero-extended to the full address width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_op | input | 2 | Operation code |
| req_mode | input | 2 | Completion detection mode |
| req_addr | input | AW | Target byte, sector or block address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle timeout pulse |
| fl_wr | output | 1 | One-cycle flash write strobe |
| fl_rd | output | 1 | One-cycle flash read strobe |
| fl_addr | output | AW | Flash address for the strobe |
| fl_wdata | output | 8 | Flash write data |
| fl_rvalid | input | 1 | Read data valid |
| fl_rdata | input | 8 | Flash read data |

## Verification
Every result has a fixed cycle, counted from the acceptance edge:

- command writes fall in cycles 1 to N;
- a polled completion falls in cycle N+2R+1;
- a fixed-wait completion falls in cycle N+W+2;
- the reset write and error fall in cycles N+T+2 and N+T+3.

R is derived by scanning the scripted read responses for the first run of three finished reads. The bench samples every output on the falling edge. It keeps a cycle counter that restarts at acceptance, and it checks each write strobe against a queue of expected writes in that same sampled cycle. At the end of each request, the bench compares the recorded cycle of `done` or `error` with the computed figure.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } flash_op_e;

    typedef enum logic [1:0] {
        MD_BIT7   = 2'd0,
        MD_TOGGLE = 2'd1,
        MD_FIXED  = 2'd2,
        MD_FIXED2 = 2'd3
    } poll_mode_e;

    typedef enum logic [1:0] {
        AK_KEY_HI,
        AK_KEY_LO,
        AK_TARGET
    } addr_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_FIX_WAIT,
        ST_ABORT,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    localparam logic [14:0] KEY_ADDR_HI = 15'h5555;
    localparam logic [14:0] KEY_ADDR_LO = 15'h2AAA;
    localparam logic [7:0]  RESET_CMD   = 8'hF0;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Number of command writes for an operation.
    function automatic logic [2:0] seq_len(input flash_op_e op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

    // Command byte for write number k of the sequence.
    function automatic logic [7:0] cmd_byte(input flash_op_e op, input logic [2:0] k,
                                            input logic [7:0] d);
        logic [7:0] b;
        unique case (k)
            3'd0, 3'd3: b = 8'hAA;
            3'd1, 3'd4: b = 8'h55;
            3'd2:       b = (op == OP_PROG) ? 8'hA0 : 8'h80;
            default: begin
                unique case (op)
                    OP_SECT: b = 8'h30;
                    OP_BLK:  b = 8'h50;
                    default: b = 8'h10;
                endcase
            end
        endcase
        if (op == OP_PROG && k == 3'd3) b = d;
        return b;
    endfunction

    // Address kind for write number k of the sequence.
    function automatic addr_kind_e cmd_addr(input flash_op_e op, input logic [2:0] k);
        addr_kind_e a;
        unique case (k)
            3'd1, 3'd4: a = AK_KEY_LO;
            3'd3:       a = (op == OP_PROG) ? AK_TARGET : AK_KEY_HI;
            3'd5:       a = (op == OP_CHIP) ? AK_KEY_HI : AK_TARGET;
            default:    a = AK_KEY_HI;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status
    import flash_seq_pkg::*;
(
    input  poll_mode_e mode,
    input  logic       exp_b7,
    input  logic       rd_b7,
    input  logic       rd_b6,
    input  logic       prev_b6,
    input  logic       prev_ok,
    output logic       hit
);
    always_comb begin
        if (mode == MD_TOGGLE) begin
            hit = prev_ok && (rd_b6 == prev_b6);
        end else begin
            hit = (rd_b7 == exp_b7);
        end
    end
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 20,
    parameter int CYC_PER_US = 100,
    parameter int TMO_PROG   = 20 * CYC_PER_US,
    parameter int TMO_ERASE  = 25000 * CYC_PER_US,
    parameter int TMO_CHIP   = 100000 * CYC_PER_US,
    parameter int WAIT_PROG  = 14 * CYC_PER_US,
    parameter int WAIT_ERASE = 18000 * CYC_PER_US,
    parameter int WAIT_CHIP  = 70000 * CYC_PER_US
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          fl_wr,
    output logic          fl_rd,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    input  logic          fl_rvalid,
    input  logic [7:0]    fl_rdata
);
    localparam int MAXL = max_of3(max_of3(TMO_PROG, TMO_ERASE, TMO_CHIP),
                                  max_of3(WAIT_PROG, WAIT_ERASE, WAIT_CHIP), 1);
    localparam int TW = $clog2(MAXL + 1) + 1;
    localparam logic [TW-1:0] LIM_TP = TW'(TMO_PROG);
    localparam logic [TW-1:0] LIM_TE = TW'(TMO_ERASE);
    localparam logic [TW-1:0] LIM_TC = TW'(TMO_CHIP);
    localparam logic [TW-1:0] LIM_WP = TW'(WAIT_PROG);
    localparam logic [TW-1:0] LIM_WE = TW'(WAIT_ERASE);
    localparam logic [TW-1:0] LIM_WC = TW'(WAIT_CHIP);

    seq_state_e    state_q, state_d;
    flash_op_e     op_q;
    poll_mode_e    mode_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [2:0]    step_q;
    logic [1:0]    run_q;
    logic          prev_b6_q, prev_ok_q;

    logic          fixed_mode, expired, timer_clr, hit, exp_b7;
    logic [TW-1:0] limit;
    logic          unused_rd;

    assign unused_rd  = ^fl_rdata[5:0];
    assign fixed_mode = mode_q[1];
    assign exp_b7     = (op_q == OP_PROG) ? data_q[7] : 1'b1;
    assign timer_clr  = !(state_q inside {ST_RD_ISSUE, ST_RD_WAIT, ST_FIX_WAIT});

    always_comb begin
        unique case (op_q)
            OP_PROG: limit = fixed_mode ? LIM_WP : LIM_TP;
            OP_CHIP: limit = fixed_mode ? LIM_WC : LIM_TC;
            default: limit = fixed_mode ? LIM_WE : LIM_TE;
        endcase
    end

    flash_seq_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (timer_clr),
        .limit   (limit),
        .expired (expired)
    );

    flash_seq_status u_status (
        .mode    (mode_q),
        .exp_b7  (exp_b7),
        .rd_b7   (fl_rdata[7]),
        .rd_b6   (fl_rdata[6]),
        .prev_b6 (prev_b6_q),
        .prev_ok (prev_ok_q),
        .hit     (hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_UNLOCK;
            ST_UNLOCK:   if (step_q == seq_len(op_q) - 3'd1)
                             state_d = fixed_mode ? ST_FIX_WAIT : ST_RD_ISSUE;
            ST_RD_ISSUE: state_d = expired ? ST_ABORT : ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (expired)                          state_d = ST_ABORT;
                else if (fl_rvalid && hit && run_q == 2'd2) state_d = ST_DONE;
                else if (fl_rvalid)                   state_d = ST_RD_ISSUE;
            end
            ST_FIX_WAIT: if (expired) state_d = ST_DONE;
            ST_ABORT:    state_d = ST_FAIL;
            ST_DONE:     state_d = ST_IDLE;
            ST_FAIL:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Request context and polling history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_PROG;
            mode_q    <= MD_BIT7;
            addr_q    <= '0;
            data_q    <= '0;
            step_q    <= '0;
            run_q     <= '0;
            prev_b6_q <= 1'b0;
            prev_ok_q <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            op_q      <= flash_op_e'(req_op);
            mode_q    <= poll_mode_e'(req_mode);
            addr_q    <= req_addr;
            data_q    <= req_data;
            step_q    <= '0;
            run_q     <= '0;
            prev_ok_q <= 1'b0;
        end else if (state_q == ST_UNLOCK) begin
            step_q <= step_q + 3'd1;
        end else if (state_q == ST_RD_WAIT && fl_rvalid && !expired) begin
            prev_b6_q <= fl_rdata[6];
            prev_ok_q <= 1'b1;
            run_q     <= hit ? run_q + 2'd1 : 2'd0;
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        error     = (state_q == ST_FAIL);
        fl_wr     = 1'b0;
        fl_rd     = 1'b0;
        fl_addr   = '0;
        fl_wdata  = '0;
        unique case (state_q)
            ST_UNLOCK: begin
                fl_wr    = 1'b1;
                fl_wdata = cmd_byte(op_q, step_q, data_q);
                unique case (cmd_addr(op_q, step_q))
                    AK_KEY_HI: fl_addr = AW'(KEY_ADDR_HI);
                    AK_KEY_LO: fl_addr = AW'(KEY_ADDR_LO);
                    default:   fl_addr = addr_q;
                endcase
            end
            ST_RD_ISSUE: begin
                fl_rd   = !expired;
                fl_addr = addr_q;
            end
            ST_ABORT: begin
                fl_wr    = 1'b1;
                fl_addr  = AW'(KEY_ADDR_HI);
                fl_wdata = RESET_CMD;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_wr_seq_chk.sv
module flash_wr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       fl_wr,
    input logic       fl_rd,
    input logic [7:0] fl_wdata
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_wr && !fl_rd && !done && !error));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    assert_first_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (fl_wr && fl_wdata == 8'hAA));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    assert_result_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !busy);

    assert_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, error}));

    assert_reset_before_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> ($past(fl_wr) && $past(fl_wdata) == 8'hF0));
endmodule

bind flash_wr_seq flash_wr_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .fl_wr     (fl_wr),
    .fl_rd     (fl_rd),
    .fl_wdata  (fl_wdata)
);

// File: tb/test_flash_wr_seq.sv
`timescale 1ns/1ps
module test_flash_wr_seq;
    localparam int AW = 20;
    localparam int TP = 40, TE = 60, TC = 80;
    localparam int WP = 5,  WE = 9,  WC = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_mode = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          busy, done, error, fl_wr, fl_rd;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_rvalid = 1'b0;
    logic [7:0]    fl_rdata = '0;

    flash_wr_seq #(
        .AW(AW), .TMO_PROG(TP), .TMO_ERASE(TE), .TMO_CHIP(TC),
        .WAIT_PROG(WP), .WAIT_ERASE(WE), .WAIT_CHIP(WC)
    ) i_flash_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .error(error), .fl_wr(fl_wr), .fl_rd(fl_rd),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rd_cnt = 0, done_cyc = 0, err_cyc = 0, last_wr_cyc = 0;
    bit exp_busy = 0;
    logic [7:0]    last_wr_data = '0;
    logic [AW-1:0] tgt = '0;
    logic [7:0]    fill = 8'hFF;
    logic [27:0]   exp_wr[$];
    logic [7:0]    resp_q[$];

    // Flash model: answers each read strobe one cycle later.
    always @(posedge clk) begin
        fl_rvalid <= 1'b0;
        if (fl_rd) begin
            fl_rvalid <= 1'b1;
            if (resp_q.size() > 0) fl_rdata <= resp_q.pop_front();
            else                   fl_rdata <= fill;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic monitor();
        logic [27:0] e;
        if (exp_busy) begin
            chk(busy === 1'b1 && req_ready === 1'b0, "R2", "busy/ready while active",
                {busy, req_ready}, 2'b10);
        end else begin
            chk(busy === 1'b0 && req_ready === 1'b1 && !fl_wr && !fl_rd && !done && !error,
                "R1", "idle outputs", {busy, req_ready, fl_wr, fl_rd, done, error}, 6'b010000);
        end
        if (fl_wr) begin
            last_wr_cyc  = cyc;
            last_wr_data = fl_wdata;
            if (exp_wr.size() == 0) begin
                chk(1'b0, "R3", "unexpected write", {fl_addr, fl_wdata}, 0);
            end else begin
                e = exp_wr.pop_front();
                chk({fl_addr, fl_wdata} == e, "R4", "write addr/data", {fl_addr, fl_wdata}, e);
            end
        end
        if (fl_rd) begin
            rd_cnt++;
            chk(fl_addr == tgt, "R5", "read address", fl_addr, tgt);
        end
        if (done)  done_cyc = cyc;
        if (error) err_cyc  = cyc;
        if (done || error) exp_busy = 0;
    endtask

    // Reads needed: first index closing a run of three finished reads.
    function automatic int need_reads(input int md, input bit e7, input logic [7:0] r[$]);
        int streak = 0;
        bit h;
        for (int j = 0; j < r.size(); j++) begin
            if (md == 1) h = (j > 0) && (r[j][6] == r[j-1][6]);
            else         h = (r[j][7] == e7);
            streak = h ? streak + 1 : 0;
            if (streak == 3) return j + 1;
        end
        return -1;
    endfunction

    task automatic run_op(input int op, input int md, input logic [AW-1:0] a,
                          input logic [7:0] d, input bit hold, input int exp_reads,
                          input bit exp_err, input int exp_end, input string rq);
        logic [AW-1:0] hi = 20'h05555, lo = 20'h02AAA;
        exp_wr.delete();
        exp_wr.push_back({hi, 8'hAA});
        exp_wr.push_back({lo, 8'h55});
        if (op == 0) begin
            exp_wr.push_back({hi, 8'hA0});
            exp_wr.push_back({a, d});
        end else begin
            exp_wr.push_back({hi, 8'h80});
            exp_wr.push_back({hi, 8'hAA});
            exp_wr.push_back({lo, 8'h55});
            if (op == 1)      exp_wr.push_back({a, 8'h30});
            else if (op == 2) exp_wr.push_back({a, 8'h50});
            else              exp_wr.push_back({hi, 8'h10});
        end
        if (exp_err) exp_wr.push_back({hi, 8'hF0});
        tgt = a; rd_cnt = 0; done_cyc = 0; err_cyc = 0;
        req_valid = 1'b1; req_op = 2'(op); req_mode = 2'(md); req_addr = a; req_data = d;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        req_op = 2'(op ^ 1); req_addr = ~a;
        cyc = 1; exp_busy = 1;
        monitor();
        while (done_cyc == 0 && err_cyc == 0 && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            monitor();
            if (done_cyc != 0 || err_cyc != 0) req_valid = 1'b0;
        end
        if (exp_err) begin
            chk(err_cyc == exp_end, rq, "error cycle", err_cyc, exp_end);
            chk(done_cyc == 0, "R9", "no done on timeout", done_cyc, 0);
            chk(last_wr_cyc == exp_end - 1 && last_wr_data == 8'hF0, "R9",
                "reset write cycle", last_wr_cyc, exp_end - 1);
        end else begin
            chk(done_cyc == exp_end, rq, "done cycle", done_cyc, exp_end);
            chk(err_cyc == 0, rq, "no error", err_cyc, 0);
        end
        if (exp_reads >= 0) chk(rd_cnt == exp_reads, rq, "status reads", rd_cnt, exp_reads);
        chk(exp_wr.size() == 0, "R3", "writes outstanding", exp_wr.size(), 0);
        @(negedge clk);
        cyc++;
        monitor();
    endtask

    task automatic poll_case(input int op, input int md, input logic [AW-1:0] a,
                             input logic [7:0] d, input logic [7:0] fl, input string rq);
        int r, n;
        bit e7;
        e7 = (op == 0) ? d[7] : 1'b1;
        r = need_reads(md, e7, resp_q);
        n = (op == 0) ? 4 : 6;
        fill = fl;
        run_op(op, md, a, d, 1'b0, r, 1'b0, n + 2 * r + 1, rq);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5.0);
        n_fail++;
        $display("FAIL watchdog all actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        monitor();                                         // R1 reset state

        // R3 R5 R7: program, bit-7 polling, clean run
        resp_q = '{8'hFF, 8'hFF, 8'h5A, 8'h5A, 8'h5A};
        poll_case(0, 0, 20'h12345, 8'h5A, 8'hFF, "R7");

        // R7: program with a broken run during confirmation
        resp_q = '{8'h5A, 8'hFF, 8'h5A, 8'h5A, 8'hDA, 8'h5A, 8'h5A, 8'h5A};
        poll_case(0, 0, 20'h00F10, 8'h5A, 8'hFF, "R7");

        // R4 R5: sector erase, bit-7 polling expects 1
        resp_q = '{8'h00, 8'h00, 8'h80, 8'h80, 8'h80};
        poll_case(1, 0, 20'h4F000, 8'h00, 8'h00, "R5");

        // R6: block erase, toggle comparison
        resp_q = '{8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00};
        poll_case(2, 1, 20'hA0000, 8'h00, 8'h40, "R6");

        // R6 R7: chip erase, toggle with interrupted run
        resp_q = '{8'h40, 8'h00, 8'h00, 8'h00, 8'h40, 8'h40, 8'h40, 8'h40};
        poll_case(3, 1, 20'h00000, 8'h00, 8'h00, "R6");

        // R8 R2: fixed-wait program, req_valid held through the busy period
        resp_q.delete();
        run_op(0, 2, 20'h00777, 8'h3C, 1'b1, 0, 1'b0, 4 + WP + 2, "R8");

        // R8: fixed-wait chip erase
        run_op(3, 2, 20'h00000, 8'h00, 1'b0, 0, 1'b0, 6 + WC + 2, "R8");

        // R10 R8: mode 3 also selects fixed wait; sector erase
        run_op(1, 3, 20'h23000, 8'h00, 1'b0, 0, 1'b0, 6 + WE + 2, "R10");

        // R9: program timeout in bit-7 mode
        fill = 8'hFF;
        run_op(0, 0, 20'h05A5A, 8'h11, 1'b0, -1, 1'b1, 4 + TP + 3, "R9");

        // R9: chip erase timeout in bit-7 mode
        fill = 8'h00;
        run_op(3, 0, 20'h00000, 8'h00, 1'b0, -1, 1'b1, 6 + TC + 3, "R9");

        // R2 R9: a normal request after a timeout
        resp_q = '{8'h80, 8'h80, 8'h80};
        poll_case(2, 0, 20'h30000, 8'h00, 8'h80, "R2");

        summary();
        $finish;
    end
endmodule